// File: doc/BRIEF.md
# Windowed Address Throttle with Per-Period Word Budget

This block sits between an AXI manager and a subordinate and limits how quickly new transactions may start. A free-running timer splits time into repeating periods. Each period is an open window, during which read and write address handshakes may pass, followed by a closed window, during which both address channels are held off. On top of that gating, a budget counter tallies every data beat that moves on the read data and write data channels. Once the tally for the current period reaches a configured word cap, no further address is accepted until the next period begins.

Data channels are never gated. A burst whose address was accepted completes even when it runs past the budget, and the budget is cleared at every period boundary, so any overshoot is forgotten. Only the valid/ready handshake wires are modelled; payloads travel beside the block. The three configuration inputs are expected to change only while reset is asserted.

Top module: `bwt_throttle`

## Requirements
- R1: After reset release, the first `cfg_on_len` cycles form the open window and the next `cfg_off_len` cycles form the closed window, and this period of `cfg_on_len + cfg_off_len` cycles repeats without gaps.
- R2: During a closed window, `m_arvalid`, `m_awvalid`, `s_arready` and `s_awready` are all low.
- R3: During an open window with budget remaining, `m_arvalid` equals `s_arvalid`, `s_arready` equals `m_arready`, and the same holds for the write address channel.
- R4: Each cycle with `m_rvalid && s_rready` adds one word, and each cycle with `s_wvalid && m_wready` adds one word, to the period's tally; once the tally is at least a nonzero `cfg_word_cap`, both address channels are blocked as in R2 for the rest of the period, so words per period stay below the cap plus one burst per channel.
- R5: A `cfg_word_cap` of 0 removes the budget limit.
- R6: The tally returns to zero at the first cycle of each period; words counted in the previous period, including overshoot, do not reduce the new budget.
- R7: With both window lengths zero, gating and budget are both disabled and the address channels always pass.
- R8: With `cfg_off_len` zero and `cfg_on_len` nonzero, the window never closes, and the budget still clears every `cfg_on_len` cycles.
- R9: With `cfg_on_len` zero and `cfg_off_len` nonzero, the address channels are blocked at all times.
- R10: Data channel signals pass straight through in both directions in every cycle (`s_rvalid = m_rvalid`, `m_rready = s_rready`, `m_wvalid = s_wvalid`, `s_wready = m_wready`).
- R11: In the first cycle after reset release the open window has started and the tally is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_on_len | input | 16 | Open window length in cycles |
| cfg_off_len | input | 16 | Closed window length in cycles |
| cfg_word_cap | input | 16 | Data words allowed per period, 0 for no limit |
| s_arvalid | input | 1 | Read address valid from manager |
| s_arready | output | 1 | Read address ready to manager |
| m_arvalid | output | 1 | Read address valid to subordinate |
| m_arready | input | 1 | Read address ready from subordinate |
| s_awvalid | input | 1 | Write address valid from manager |
| s_awready | output | 1 | Write address ready to manager |
| m_awvalid | output | 1 | Write address valid to subordinate |
| m_awready | input | 1 | Write address ready from subordinate |
| s_wvalid | input | 1 | Write data valid from manager |
| s_wready | output | 1 | Write data ready to manager |
| m_wvalid | output | 1 | Write data valid to subordinate |
| m_wready | input | 1 | Write data ready from subordinate |
| m_rvalid | input | 1 | Read data valid from subordinate |
| m_rready | output | 1 | Read data ready to subordinate |
| s_rvalid | output | 1 | Read data valid to manager |
| s_rready | input | 1 | Read data ready from manager |

## Verification
The hardest state to reach is budget exhaustion inside an open window while a burst on the other channel is still draining, because it needs enough accepted addresses and enough data beats to land in one period before the window closes. The stimulus uses a small cap against long open windows, random bursts of one to four beats on both channels and random ready throttling, so the tally crosses the cap at varied points, sometimes in the cycle a period ends. A coverage count confirms that budget blocking was seen in an open window, and degenerate window settings are run as directed cases.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  typedef enum logic {
    PH_OPEN = 1'b0,
    PH_SHUT = 1'b1
  } phase_e;

  localparam int unsigned NUM_ACH = 2;  // read and write address channels
  localparam int unsigned AR_IDX  = 0;
  localparam int unsigned AW_IDX  = 1;
endpackage

// File: rtl/bwt_period_timer.sv
module bwt_period_timer
  import bwt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] on_len,
  input  logic [CNT_W-1:0] off_len,
  output logic             win_open,
  output logic             gate_off,
  output logic             period_wrap
);
  localparam int unsigned EXT_W = CNT_W + 1;

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [EXT_W-1:0] cnt_inc;
  logic             last_open, last_shut;

  assign gate_off  = (on_len == '0) && (off_len == '0);
  assign cnt_en    = !gate_off;
  assign cnt_inc   = {1'b0, cnt_q} + EXT_W'(1);
  assign last_open = cnt_inc >= {1'b0, on_len};
  assign last_shut = cnt_inc >= {1'b0, off_len};
  assign win_open  = gate_off || ((ph_q == PH_OPEN) && (on_len != '0));

  always_comb begin
    ph_d        = ph_q;
    cnt_d       = cnt_q + CNT_W'(1);
    period_wrap = 1'b0;
    unique case (ph_q)
      PH_OPEN: begin
        if (last_open) begin
          cnt_d = '0;
          if (off_len != '0) ph_d = PH_SHUT;
          else               period_wrap = 1'b1;
        end
      end
      PH_SHUT: begin
        if (last_shut) begin
          cnt_d = '0;
          if (on_len != '0) begin
            ph_d        = PH_OPEN;
            period_wrap = 1'b1;
          end
        end
      end
      default: ph_d = PH_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_OPEN;
      cnt_q <= '0;
    end else if (cnt_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  // R1: position counter stays inside the current window
  p_open_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_off && ph_q == PH_OPEN && on_len != '0) |-> (cnt_q < on_len));
  p_shut_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SHUT && off_len != '0) |-> (cnt_q < off_len));
  // R8: a zero closed length never enters the closed phase
  p_never_shut_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (off_len == '0) |-> (ph_q == PH_OPEN));
endmodule

// File: rtl/bwt_budget.sv
module bwt_budget #(
  parameter int unsigned CAP_W  = 16,
  parameter int unsigned USED_W = CAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] cap,
  input  logic [1:0]       beats,
  input  logic             period_wrap,
  output logic             budget_ok
);
  localparam int unsigned SUM_W = USED_W + 1;

  logic [USED_W-1:0] used_q, used_d;
  logic [SUM_W-1:0]  sum;
  logic              used_en;

  assign sum       = {1'b0, used_q} + SUM_W'(beats);
  assign used_en   = period_wrap || (beats != 2'd0);
  assign budget_ok = (cap == '0) || (used_q < USED_W'(cap));

  always_comb begin
    if (period_wrap)     used_d = '0;
    else if (sum[USED_W]) used_d = '1;
    else                 used_d = sum[USED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       used_q <= '0;
    else if (used_en) used_q <= used_d;
  end

  // R6: tally is empty at the start of every period
  p_clear_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_wrap |=> (used_q == '0));
  // R4: tally only grows inside a period
  p_no_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_wrap && used_q != '0) |=> (used_q != '0));
endmodule

// File: rtl/bwt_chan_gate.sv
module bwt_chan_gate (
  input  logic allow,
  input  logic up_valid,
  output logic up_ready,
  output logic dn_valid,
  input  logic dn_ready
);
  assign dn_valid = up_valid && allow;
  assign up_ready = dn_ready && allow;
endmodule

// File: rtl/bwt_throttle.sv
module bwt_throttle
  import bwt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_on_len,
  input  logic [CNT_W-1:0] cfg_off_len,
  input  logic [CAP_W-1:0] cfg_word_cap,
  input  logic             s_arvalid,
  output logic             s_arready,
  output logic             m_arvalid,
  input  logic             m_arready,
  input  logic             s_awvalid,
  output logic             s_awready,
  output logic             m_awvalid,
  input  logic             m_awready,
  input  logic             s_wvalid,
  output logic             s_wready,
  output logic             m_wvalid,
  input  logic             m_wready,
  input  logic             m_rvalid,
  output logic             m_rready,
  output logic             s_rvalid,
  input  logic             s_rready
);
  logic       win_open, gate_off, period_wrap, budget_ok, allow;
  logic       r_beat, w_beat;
  logic [1:0] beats;

  logic [NUM_ACH-1:0] up_valid, up_ready, dn_valid, dn_ready;

  // data channels are observed, never gated
  assign s_rvalid = m_rvalid;
  assign m_rready = s_rready;
  assign m_wvalid = s_wvalid;
  assign s_wready = m_wready;

  assign r_beat = m_rvalid && s_rready;
  assign w_beat = s_wvalid && m_wready;
  assign beats  = {1'b0, r_beat} + {1'b0, w_beat};

  bwt_period_timer #(.CNT_W(CNT_W)) timer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_len      (cfg_on_len),
    .off_len     (cfg_off_len),
    .win_open    (win_open),
    .gate_off    (gate_off),
    .period_wrap (period_wrap)
  );

  bwt_budget #(.CAP_W(CAP_W)) budget_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap         (cfg_word_cap),
    .beats       (beats),
    .period_wrap (period_wrap),
    .budget_ok   (budget_ok)
  );

  assign allow = gate_off || (win_open && budget_ok);

  assign up_valid[AR_IDX] = s_arvalid;
  assign up_valid[AW_IDX] = s_awvalid;
  assign dn_ready[AR_IDX] = m_arready;
  assign dn_ready[AW_IDX] = m_awready;
  assign s_arready = up_ready[AR_IDX];
  assign s_awready = up_ready[AW_IDX];
  assign m_arvalid = dn_valid[AR_IDX];
  assign m_awvalid = dn_valid[AW_IDX];

  for (genvar g = 0; g < NUM_ACH; g++) begin : g_ach
    bwt_chan_gate gate_i (
      .allow    (allow),
      .up_valid (up_valid[g]),
      .up_ready (up_ready[g]),
      .dn_valid (dn_valid[g]),
      .dn_ready (dn_ready[g])
    );
  end

  // R2: no address handshake while the window is closed
  p_closed_no_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> !(s_arvalid && s_arready) && !(s_awvalid && s_awready));
  // R4: exhausted budget blocks both address channels
  p_exhausted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_off && !budget_ok) |-> !m_arvalid && !m_awvalid);
  // R7: disabled gating passes both address channels
  p_disabled_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |-> (s_arready == m_arready) && (s_awready == m_awready));
  // R10: data beats are never held off
  p_data_through_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rvalid == s_rvalid) && (s_wready == m_wready));
endmodule

// File: tb/bwt_throttle_tb_top.sv
`timescale 1ns/1ps
module bwt_throttle_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_on_len, cfg_off_len, cfg_word_cap;
  logic s_arvalid, s_arready, m_arvalid, m_arready;
  logic s_awvalid, s_awready, m_awvalid, m_awready;
  logic s_wvalid, s_wready, m_wvalid, m_wready;
  logic m_rvalid, m_rready, s_rvalid, s_rready;

  int n_checks = 0;
  int n_fail   = 0;
  int blk_cov  = 0;

  always #2.5 clk = ~clk;

  bwt_throttle dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_open(int k, int on, int off);
    if (on == 0 && off == 0) return 1'b1;
    if (on == 0) return 1'b0;
    return (k % (on + off)) < on;
  endfunction

  task automatic run_case(input int on, input int off, input int cap,
                          input int ncyc, input int maxb);
    int  k = 0, used = 0, words = 0, rd_pend = 0, wr_pend = 0, per;
    bit  allow, open, rb, wb, arhs, awhs;
    string tag;
    per = on + off;
    cfg_on_len = 16'(on); cfg_off_len = 16'(off); cfg_word_cap = 16'(cap);
    rst_n = 1'b0;
    {s_arvalid, m_arready, s_awvalid, m_awready} = '0;
    {s_wvalid, m_wready, m_rvalid, s_rready} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      s_arvalid = (rd_pend == 0) && ($urandom % 3 != 0);
      m_arready = ($urandom % 4 != 0);
      s_awvalid = (wr_pend == 0) && ($urandom % 3 != 0);
      m_awready = ($urandom % 4 != 0);
      m_rvalid  = (rd_pend > 0) && ($urandom % 4 != 0);
      s_rready  = ($urandom % 4 != 0);
      s_wvalid  = (wr_pend > 0) && ($urandom % 4 != 0);
      m_wready  = ($urandom % 4 != 0);
      if (k == 0) begin s_arvalid = 1'b1; m_arready = 1'b1; end
      #1;
      open  = model_open(k, on, off);
      allow = (on == 0 && off == 0) ? 1'b1 : (open && (cap == 0 || used < cap));
      if (k == 0)                          tag = "R11";
      else if (on == 0 && off == 0)        tag = "R7";
      else if (on == 0)                    tag = "R9";
      else if (off == 0)                   tag = (k % per == 0) ? "R6" : "R8";
      else if (k % per == 0)               tag = "R6";
      else if (k % per == on)              tag = "R1";
      else if (!open)                      tag = "R2";
      else if (cap != 0 && used >= cap)    tag = "R4";
      else if (cap == 0)                   tag = "R5";
      else                                 tag = "R3";
      if (open && !allow && off + on != 0) blk_cov++;
      chk(m_arvalid == (s_arvalid && allow), tag, m_arvalid, s_arvalid && allow);
      chk(s_arready == (m_arready && allow), tag, s_arready, m_arready && allow);
      chk(m_awvalid == (s_awvalid && allow), tag, m_awvalid, s_awvalid && allow);
      chk(s_awready == (m_awready && allow), tag, s_awready, m_awready && allow);
      chk((s_rvalid == m_rvalid) && (m_rready == s_rready) &&
          (m_wvalid == s_wvalid) && (s_wready == m_wready), "R10",
          {s_rvalid, m_rready, m_wvalid, s_wready},
          {m_rvalid, s_rready, s_wvalid, m_wready});
      arhs = s_arvalid && m_arready && allow;
      awhs = s_awvalid && m_awready && allow;
      rb   = m_rvalid && s_rready;
      wb   = s_wvalid && m_wready;
      if (rb) rd_pend--;
      if (wb) wr_pend--;
      if (arhs) rd_pend += 1 + int'($urandom % maxb);
      if (awhs) wr_pend += 1 + int'($urandom % maxb);
      used  += int'(rb) + int'(wb);
      words += int'(rb) + int'(wb);
      k++;
      if (per != 0 && on != 0 && k % per == 0) begin
        if (cap != 0)
          chk(words <= cap + 2 * maxb, "R4", words, cap + 2 * maxb);
        used = 0;
        words = 0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    run_case(20, 10, 0, 400, 4);    // R1 R2 R5
    blk_cov = 0;
    run_case(30, 10, 12, 800, 4);   // R3 R4 R6
    chk(blk_cov > 0, "R4", blk_cov, 1);
    run_case(0, 0, 5, 300, 4);      // R7
    blk_cov = 0;
    run_case(16, 0, 8, 500, 4);     // R8
    chk(blk_cov > 0, "R8", blk_cov, 1);
    run_case(0, 7, 3, 200, 4);      // R9
    run_case(1, 1, 1, 300, 2);      // R1 R6 shortest period
    for (int i = 0; i < 4; i++)
      run_case(1 + int'($urandom % 40), int'($urandom % 20),
               int'($urandom % 16), 600, 1 + int'($urandom % 4));
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule